// File: doc/BRIEF.md
# Pipelined Set-Bit Enumerator

This block takes a wide bitmask, for instance the set of candidate rules left over after a coarse filter, and lists the position of every bit that is set in it, one position per cycle, lowest position first. A consumer that must handle each flagged item in turn, such as a dispatcher that hands every candidate to a worker, reads the positions off the output in order. The ordering is fixed: a lower position always comes out before a higher one.

Internally the mask is held in an input stage that removes its lowest set bit on every advance. Each such snapshot then goes through a pipelined binary tree, whose leaves are the mask bits, that reduces it to the position of its lowest set bit. A new snapshot enters every cycle, so the tree is kept busy and its depth grows only with the logarithm of the width. A sideband pipeline runs in step with the tree and carries a valid flag, a final-entry flag and an all-zero flag. One stall signal, taken from output back-pressure, freezes every stage at once.

Top module: `bitmask_walker`

## Requirements
- R1: While reset is low and in the first cycle after it is released, out_valid is 0 and load_ready is 1.
- R2: For an accepted mask, the index of each set bit comes out exactly once, in strictly ascending order, and no other index is produced.
- R3: The first output of an accepted mask appears log2(WIDTH)+1 cycles after the cycle in which load_valid and load_ready were both high (5 cycles for WIDTH=16).
- R4: While out_ready stays high, the indices of one mask come out in consecutive cycles with no gaps.
- R5: out_last is 1 together with the highest set index of a mask and 0 with every other index.
- R6: An all-zero mask produces exactly one output cycle with out_empty=1, out_last=1 and out_index=0.
- R7: load_ready is 0 while the input stage still holds set bits that have not yet entered the tree, and while the output is stalled. A load_valid offered while load_ready is 0 has no effect on the output sequence.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_index, out_last and out_empty keep their values. The next entry follows once out_ready returns to 1.
- R9: A new mask is accepted in the same cycle in which the final entry of the previous mask enters the tree, so that its first index follows the previous last index with no idle cycle.
- R10: WIDTH is a power of two of at least 2, and out_index is log2(WIDTH) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | A mask is offered on load_mask |
| load_mask | input | WIDTH | Bitmask to enumerate; bit i stands for index i |
| load_ready | output | 1 | The offered mask is taken at this clock edge |
| out_ready | input | 1 | The consumer takes the current output |
| out_valid | output | 1 | An output entry is present |
| out_index | output | IDX_W | Position of a set bit; 0 on an empty entry |
| out_last | output | 1 | Final entry of the current mask |
| out_empty | output | 1 | The mask had no set bits |

## Verification
A mask taken at a clock edge shows its first index log2(WIDTH)+1 edges later, and after that one more index appears on each edge while out_ready is high. A stall freezes the output until the edge after out_ready rises. The bench drives every input and samples every output on the falling edge, after a short settle delay. It counts those falling edges from the load edge, so each index, last flag and empty flag is compared in exactly the cycle in which it is due. A missing, early, late or repeated entry therefore shows up as a mismatch at that position.

// File: rtl/bmw_pkg.sv
// Package: shared types for the set-bit enumerator.
// Assumes: nothing beyond IEEE 1800-2017.
package bmw_pkg;

    // Sideband that travels beside each snapshot through the tree.
    typedef struct packed {
        logic valid;   // stage holds an entry
        logic last;    // entry is the final one of its mask
        logic empty;   // mask had no set bits
    } bmw_tag_t;

endpackage

// File: rtl/bmw_feed.sv
// Module: input stage. Holds the remaining bits of the current mask and
// removes the lowest set bit on every advance, so that a fresh snapshot
// enters the tree each cycle.
// Assumes: adv is the global advance; a mask is taken only with load_ready.
module bmw_feed #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                load_valid,
    input  logic [W-1:0]        load_mask,
    output logic                load_ready,
    output logic [W-1:0]        leaf_bits,
    output bmw_pkg::bmw_tag_t   tag_out
);

    logic [W-1:0] bits_q;
    logic         valid_q;
    logic [W-1:0] rest_c;
    logic         final_c;

    // Snapshot that follows once the lowest set bit has been served.
    assign rest_c  = bits_q & (bits_q - W'(1));
    assign final_c = (rest_c == '0);

    // Accept a mask when idle or when the current mask is on its final entry.
    assign load_ready = adv && (!valid_q || final_c);

    assign leaf_bits     = bits_q;
    assign tag_out.valid = valid_q;
    assign tag_out.last  = final_c;
    assign tag_out.empty = (bits_q == '0);

    // Load a new mask or step to the next snapshot of the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            bits_q  <= '0;
        end else if (adv) begin
            if (load_valid && load_ready) begin
                valid_q <= 1'b1;
                bits_q  <= load_mask;
            end else if (valid_q && !final_c) begin
                bits_q  <= rest_c;
            end else begin
                valid_q <= 1'b0;
                bits_q  <= '0;
            end
        end
    end

    // R7: an accepted mask is what the input stage holds afterwards.
    p_take_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && load_ready |=> valid_q && (bits_q == $past(load_mask)));

    // R2: each advance on a non-final snapshot serves exactly one bit.
    p_one_bit_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv && valid_q && !final_c |=>
            valid_q && ($countones(bits_q) + 1 == $countones($past(bits_q))));

endmodule

// File: rtl/bmw_tree.sv
// Module: pipelined binary reduction tree. The leaves are the snapshot bits;
// each internal node registers whether its subtree has a set bit and the
// index of the lowest one, preferring its lower-index child.
// Assumes: W is a power of two, W >= 2. Nodes use heap numbering: node n
// has children 2n and 2n+1; leaf i is number W+i; node 1 is the root.
module bmw_tree #(
    parameter int W    = 32,
    parameter int IW   = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adv,
    input  logic [W-1:0]   leaf_bits,
    output logic           root_any,
    output logic [IW-1:0]  root_idx
);

    logic [W-1:1]             any_q;
    logic [W-1:1][IW-1:0]     idx_q;
    logic [2*W-1:1]           all_any;
    logic [2*W-1:1][IW-1:0]   all_idx;

    // Gather leaves and registered nodes into one heap-numbered view.
    always_comb begin
        all_any = {leaf_bits, any_q};
        for (int n = 1; n < W; n++) begin
            all_idx[n] = idx_q[n];
        end
        for (int i = 0; i < W; i++) begin
            all_idx[W + i] = IW'(i);
        end
    end

    // One register level per tree depth; the lower-index child wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= '0;
            idx_q <= '0;
        end else if (adv) begin
            for (int n = 1; n < W; n++) begin
                any_q[n] <= all_any[2*n] | all_any[2*n + 1];
                idx_q[n] <= all_any[2*n] ? all_idx[2*n] : all_idx[2*n + 1];
            end
        end
    end

    assign root_any = any_q[1];
    assign root_idx = idx_q[1];

endmodule

// File: rtl/bmw_tag_pipe.sv
// Module: sideband delay line that keeps valid, last and empty aligned with
// the tree, one register per tree level.
// Assumes: DEPTH >= 1 and equals the number of tree register levels.
module bmw_tag_pipe #(
    parameter int DEPTH = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  bmw_pkg::bmw_tag_t   tag_in,
    output bmw_pkg::bmw_tag_t   tag_out
);

    bmw_pkg::bmw_tag_t tag_q [DEPTH];

    // Shift the sideband forward whenever the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                tag_q[k] <= '0;
            end
        end else if (adv) begin
            tag_q[0] <= tag_in;
            for (int k = 1; k < DEPTH; k++) begin
                tag_q[k] <= tag_q[k-1];
            end
        end
    end

    assign tag_out = tag_q[DEPTH-1];

endmodule

// File: rtl/bitmask_walker.sv
// Module: top of the set-bit enumerator. Lists the index of every set bit of
// a loaded mask in ascending order, one per cycle, with a final-entry flag
// and an empty-mask entry. A single advance signal stalls all stages.
// Assumes: WIDTH is a power of two, WIDTH >= 2 (R10).
module bitmask_walker #(
    parameter  int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [WIDTH-1:0]  load_mask,
    output logic              load_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_index,
    output logic              out_last,
    output logic              out_empty
);

    localparam int DEPTH = IDX_W;

    logic               adv;
    logic [WIDTH-1:0]   leaf_bits;
    bmw_pkg::bmw_tag_t  tag_s0;
    bmw_pkg::bmw_tag_t  tag_out;
    logic               root_any;
    logic [IDX_W-1:0]   root_idx;

    // Everything moves unless an entry waits on a busy consumer.
    assign adv = !out_valid || out_ready;

    bmw_feed #(.W(WIDTH)) u_feed (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .load_valid (load_valid),
        .load_mask  (load_mask),
        .load_ready (load_ready),
        .leaf_bits  (leaf_bits),
        .tag_out    (tag_s0)
    );

    bmw_tree #(.W(WIDTH), .IW(IDX_W)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .leaf_bits (leaf_bits),
        .root_any  (root_any),
        .root_idx  (root_idx)
    );

    bmw_tag_pipe #(.DEPTH(DEPTH)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .tag_in  (tag_s0),
        .tag_out (tag_out)
    );

    assign out_valid = tag_out.valid;
    assign out_last  = tag_out.valid && tag_out.last;
    assign out_empty = tag_out.valid && tag_out.empty;
    assign out_index = (tag_out.valid && root_any) ? root_idx : '0;

    // Checking aid only: remembers the previous index of the current mask.
    logic              seen_q;
    logic [IDX_W-1:0]  prev_q;

    // Track whether a mask is part-way through and what it last produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q <= !out_last;
            prev_q <= out_index;
        end
    end

    // R8: a stalled entry stays put.
    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=>
            out_valid && $stable(out_index) && $stable(out_last) && $stable(out_empty));

    // R6: an empty entry is also final and carries index 0.
    p_empty_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> out_last && (out_index == '0));

    // R2: within one mask, indices strictly increase.
    p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && seen_q |-> (out_index > prev_q) && !out_empty);

    // R4: a taken non-final entry is followed at once by the next one.
    p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid);

endmodule

// File: tb/bitmask_walker_tb.sv
module bitmask_walker_tb;

    localparam int W     = 16;
    localparam int IW    = 4;
    localparam int LAT   = IW + 1;
    localparam int LIMIT = 100000;

    // Each vector: {mask[15:0], set-bit count[7:0], first index[3:0], last index[3:0]}
    localparam logic [31:0] VEC [8] = '{
        32'h0001_01_00,
        32'h8000_01_FF,
        32'hFFFF_10_0F,
        32'h0000_00_00,
        32'hA5A5_08_0F,
        32'h0180_02_78,
        32'h8001_02_0F,
        32'h1248_04_3C
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0;
    logic [W-1:0]  load_mask = '0;
    logic          load_ready;
    logic          out_ready = 1'b1;
    logic          out_valid;
    logic [IW-1:0] out_index;
    logic          out_last;
    logic          out_empty;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bitmask_walker #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_mask  (load_mask),
        .load_ready (load_ready),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_index  (out_index),
        .out_last   (out_last),
        .out_empty  (out_empty)
    );

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == LIMIT && !done) begin
            done = 1'b1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load one table vector and compare every entry in the cycle it is due.
    task automatic run_vec(input logic [31:0] v);
        logic [W-1:0] m;
        int cnt, first, lastidx, lat, n;
        m       = v[31:16];
        cnt     = int'(v[15:8]);
        first   = int'(v[7:4]);
        lastidx = int'(v[3:0]);
        while (!load_ready) tick();
        load_valid = 1'b1;
        load_mask  = m;
        tick();
        load_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            tick();
            lat++;
        end
        check(lat == LAT, "R3 latency", lat, LAT);
        if (cnt == 0) begin
            check(out_valid && out_empty && out_last && out_index == 0,
                  "R6 empty entry", {out_valid, out_empty, out_last}, 7);
            tick();
            check(!out_valid, "R6 single pulse", out_valid, 0);
        end else begin
            n = 0;
            for (int b = 0; b < W; b++) begin
                if (m[b]) begin
                    check(out_valid && !out_empty, "R4 entry present", out_valid, 1);
                    check(out_index == b, "R2 index", out_index, b);
                    check(out_last == (n == cnt - 1), "R5 last flag", out_last, n == cnt - 1);
                    if (n == 0) check(out_index == first, "R2 first index", out_index, first);
                    if (n == cnt - 1) check(out_index == lastidx, "R5 last index", out_index, lastidx);
                    n++;
                    tick();
                end
            end
            check(n == cnt, "R2 count", n, cnt);
            check(!out_valid, "R2 no extra entry", out_valid, 0);
        end
    endtask

    initial begin
        // R1: reset state
        tick();
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(load_ready == 1'b1, "R1 load_ready in reset", load_ready, 1);
        tick();
        rst_n = 1'b1;
        tick();
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(load_ready == 1'b1, "R1 load_ready after reset", load_ready, 1);

        // Table walk (R2 R3 R4 R5 R6 R10)
        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R9 and R7: back-to-back masks, with a refused offer in between
        begin
            int exp_idx [4] = '{0, 2, 8, 9};
            bit exp_lst [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
            while (!load_ready) tick();
            load_valid = 1'b1;
            load_mask  = 16'h0005;
            tick();
            check(load_ready == 1'b0, "R7 busy refuses load", load_ready, 0);
            load_mask = 16'hFFFF;
            tick();
            check(load_ready == 1'b1, "R9 ready on final entry", load_ready, 1);
            load_mask = 16'h0300;
            tick();
            load_valid = 1'b0;
            tick();
            tick();
            for (int k = 0; k < 4; k++) begin
                check(out_valid, "R9 contiguous output", out_valid, 1);
                check(out_index == exp_idx[k], "R9 index order", out_index, exp_idx[k]);
                check(out_last == exp_lst[k], "R5 last across masks", out_last, exp_lst[k]);
                tick();
            end
            check(!out_valid, "R7 refused mask ignored", out_valid, 0);
        end

        // R8 and R7: output stall
        out_ready = 1'b0;
        while (!load_ready) tick();
        load_valid = 1'b1;
        load_mask  = 16'h0012;
        tick();
        load_valid = 1'b0;
        for (int k = 1; k < LAT; k++) tick();
        check(out_valid && out_index == 1 && !out_last, "R8 first entry", out_index, 1);
        check(load_ready == 1'b0, "R7 stalled refuses load", load_ready, 0);
        load_valid = 1'b1;
        load_mask  = 16'hFFFF;
        tick();
        check(out_valid && out_index == 1 && !out_last, "R8 held entry", out_index, 1);
        check(load_ready == 1'b0, "R7 still refused", load_ready, 0);
        tick();
        check(out_valid && out_index == 1, "R8 held again", out_index, 1);
        load_valid = 1'b0;
        out_ready  = 1'b1;
        tick();
        check(out_valid && out_index == 4 && out_last, "R8 resumes", out_index, 4);
        tick();
        check(!out_valid, "R7 stalled offer ignored", out_valid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule